// File: doc/BRIEF.md
# Quadratic Saturating Activation Unit

This block evaluates a cheap stand-in for the hyperbolic tangent on one signed fixed-point sample per clock. Outside the interval from −2 to +2 the result is clamped to ±1. Inside that interval the result is the input with a quarter of its square taken away (for non-negative inputs) or added back (for negative inputs). The curve comes out odd, monotonic and close to tanh. It needs one multiplier, a fixed arithmetic shift, one subtracter and a few selectors. No iterative evaluation is involved.

A sample arrives on `act_in` with `act_in_vld`. The result is registered and appears on `act_out` with `act_out_vld` exactly one clock later. With the default parameters both sides are 13-bit two's complement with 10 fractional bits, so +1.0 is code 1024 and +2.0 is code 2048. The input is sorted into one of four regions, and the region drives the output selection:

- `RGN_SAT_NEG`: clamp to −1.
- `RGN_CURVE_NEG`: x + x²/4.
- `RGN_CURVE_POS`: x − x²/4.
- `RGN_SAT_POS`: clamp to +1.

Between two accepted samples the output register does not change.

Top module: `qsat_act_unit`

## Requirements
- R1: An accepted input code ≥ 2048 (x ≥ +2.0) gives `act_out` = 1024 (+1.0).
- R2: An accepted input code ≤ −2048 (x ≤ −2.0) gives `act_out` = −1024 (−1.0).
- R3: An accepted input code c with 0 ≤ c < 2048 gives `act_out` = c − floor(c²/4096), which is x − x²/4 with the square truncated toward zero.
- R4: An accepted input code c with −2048 < c < 0 gives `act_out` = c + floor(c²/4096), which is x + x²/4.
- R5: `act_out_vld` is 1 in the cycle after a cycle in which `act_in_vld` is 1, and is 0 otherwise. After reset, `act_out_vld` is 0 and `act_out` is 0.
- R6: While `act_in_vld` is 0, `act_out` keeps its last value, whatever `act_in` carries.
- R7: The output is odd. For every code c with −4096 < c < 4096, the result for −c is the negation of the result for c.
- R8: The output never decreases as the input code increases across the whole signed range −4096 … 4095.
- R9: Every valid output lies within −1024 … 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_in_vld | input | 1 | Marks `act_in` as a sample to evaluate |
| act_in | input | 13 | Signed pre-activation, 10 fractional bits |
| act_out_vld | output | 1 | Marks `act_out` as a fresh result |
| act_out | output | 13 | Signed activation result, 10 fractional bits |

## Verification
Every one of the 8192 input codes is fed back to back and compared with a value computed arithmetically. This sweep covers both saturation regions, both curve halves and the exact ±2.0 boundaries. A wrong sign selection separates from a wrong clamp threshold, and a wrong shift amount also shows up. The captured curve is then checked pairwise for oddness and stepwise for monotonic growth. These checks catch errors such as an off-by-one boundary or an asymmetric truncation, which a single-point comparison could miss. Idle cycles with a changing input then show that the output holds and that the valid flag drops.

// File: rtl/qsat_act_pkg.sv
package qsat_act_pkg;

    // Region of the input axis; selects which result the output takes.
    typedef enum logic [1:0] {
        RGN_SAT_NEG   = 2'd0,
        RGN_CURVE_NEG = 2'd1,
        RGN_CURVE_POS = 2'd2,
        RGN_SAT_POS   = 2'd3
    } qsat_region_e;

endpackage

// File: rtl/qsat_region_sel.sv
module qsat_region_sel
    import qsat_act_pkg::*;
#(
    parameter int DATA_W = 13,
    parameter int FRAC_W = 10
) (
    input  logic signed [DATA_W-1:0] x_i,
    output qsat_region_e             region_o
);

    localparam logic signed [DATA_W-1:0] POS_TWO = DATA_W'(2 << FRAC_W);
    localparam logic signed [DATA_W-1:0] NEG_TWO = -POS_TWO;

    always_comb begin
        if (x_i >= POS_TWO) begin
            region_o = RGN_SAT_POS;
        end else if (x_i <= NEG_TWO) begin
            region_o = RGN_SAT_NEG;
        end else if (x_i[DATA_W-1]) begin
            region_o = RGN_CURVE_NEG;
        end else begin
            region_o = RGN_CURVE_POS;
        end
    end

endmodule

// File: rtl/qsat_square_q.sv
module qsat_square_q #(
    parameter int DATA_W = 13,
    parameter int FRAC_W = 10
) (
    input  logic signed [DATA_W-1:0] x_i,
    output logic        [DATA_W-1:0] quarter_sq_o
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic        [PROD_W-1:0] realigned;
    logic        [PROD_W-1:0] quartered;

    // Single multiplier: full-width square, always non-negative.
    assign prod      = PROD_W'(x_i) * PROD_W'(x_i);
    // Back to FRAC_W fractional bits, then divide by four with a 2-bit shift.
    assign realigned = unsigned'(prod) >> FRAC_W;
    assign quartered = realigned >> 2;

    // Only curve-region inputs are used downstream (|x| < 2, quarter square < 1),
    // so the low DATA_W bits hold the whole value there.
    assign quarter_sq_o = quartered[DATA_W-1:0];

endmodule

// File: rtl/qsat_out_mux.sv
module qsat_out_mux
    import qsat_act_pkg::*;
#(
    parameter int DATA_W = 13,
    parameter int FRAC_W = 10
) (
    input  logic signed [DATA_W-1:0] x_i,
    input  logic        [DATA_W-1:0] quarter_sq_i,
    input  qsat_region_e             region_i,
    output logic signed [DATA_W-1:0] y_o
);

    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [DATA_W-1:0] POS_ONE = DATA_W'(1 << FRAC_W);
    localparam logic signed [DATA_W-1:0] NEG_ONE = -POS_ONE;

    logic signed [SUM_W-1:0] term;
    logic signed [SUM_W-1:0] diff;

    // Sign-steered selector feeding one subtracter.
    always_comb begin
        if (region_i == RGN_CURVE_NEG) begin
            term = -SUM_W'(signed'({1'b0, quarter_sq_i}));
        end else begin
            term = SUM_W'(signed'({1'b0, quarter_sq_i}));
        end
        diff = SUM_W'(x_i) - term;
    end

    always_comb begin
        unique case (region_i)
            RGN_SAT_NEG:   y_o = NEG_ONE;
            RGN_SAT_POS:   y_o = POS_ONE;
            RGN_CURVE_NEG: y_o = diff[DATA_W-1:0];
            RGN_CURVE_POS: y_o = diff[DATA_W-1:0];
            default:       y_o = '0;
        endcase
    end

endmodule

// File: rtl/qsat_act_unit.sv
module qsat_act_unit
    import qsat_act_pkg::*;
#(
    parameter int DATA_W = 13,
    parameter int FRAC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     act_in_vld,
    input  logic signed [DATA_W-1:0] act_in,
    output logic                     act_out_vld,
    output logic signed [DATA_W-1:0] act_out
);

    qsat_region_e             region;
    logic        [DATA_W-1:0] quarter_sq;
    logic signed [DATA_W-1:0] y_next;

    qsat_region_sel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_region (
        .x_i      (act_in),
        .region_o (region)
    );

    qsat_square_q #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_square (
        .x_i          (act_in),
        .quarter_sq_o (quarter_sq)
    );

    qsat_out_mux #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mux (
        .x_i          (act_in),
        .quarter_sq_i (quarter_sq),
        .region_i     (region),
        .y_o          (y_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_out_vld <= 1'b0;
        end else begin
            act_out_vld <= act_in_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_out <= '0;
        end else if (act_in_vld) begin
            act_out <= y_next;
        end
    end

endmodule

// File: rtl/qsat_act_chk.sv
module qsat_act_chk #(
    parameter int DATA_W = 13,
    parameter int FRAC_W = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     act_in_vld,
    input logic signed [DATA_W-1:0] act_in,
    input logic                     act_out_vld,
    input logic signed [DATA_W-1:0] act_out
);

    localparam logic signed [DATA_W-1:0] ONE_C = DATA_W'(1 << FRAC_W);
    localparam logic signed [DATA_W-1:0] TWO_C = DATA_W'(2 << FRAC_W);

    // R1
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_in_vld && act_in >= TWO_C) |=> (act_out == ONE_C));

    // R2
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_in_vld && act_in <= -TWO_C) |=> (act_out == -ONE_C));

    // R5
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_in_vld |=> act_out_vld);

    // R5
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_in_vld |=> !act_out_vld);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_in_vld |=> $stable(act_out));

    // R9
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_out_vld |-> (act_out <= ONE_C && act_out >= -ONE_C));

endmodule

bind qsat_act_unit qsat_act_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_qsat_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_in_vld  (act_in_vld),
    .act_in      (act_in),
    .act_out_vld (act_out_vld),
    .act_out     (act_out)
);

// File: tb/qsat_act_unit_tb_top.sv
module qsat_act_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 13;
    localparam int NCODES     = 1 << W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                act_in_vld = 1'b0;
    logic signed [W-1:0] act_in = '0;
    logic                act_out_vld;
    logic signed [W-1:0] act_out;

    int n_checks = 0;
    int n_errors = 0;
    int got [NCODES];

    always #(CLK_PERIOD/2) clk = ~clk;

    qsat_act_unit #(.DATA_W(W), .FRAC_W(10)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_in_vld  (act_in_vld),
        .act_in      (act_in),
        .act_out_vld (act_out_vld),
        .act_out     (act_out)
    );

    function automatic int expect_val(input int c);
        int q;
        if (c >= 2048) return 1024;
        if (c <= -2048) return -1024;
        q = (c * c) / 4096;
        if (c >= 0) return c - q;
        return c + q;
    endfunction

    task automatic check(input string req, input int act, input int exp, input int code);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s code=%0d actual=%0d expected=%0d", req, code, act, exp);
        end
    endtask

    function automatic string req_of(input int c);
        if (c >= 2048) return "R1";
        if (c <= -2048) return "R2";
        if (c >= 0) return "R3";
        return "R4";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #1;
        // R5: reset state
        check("R5", int'(act_out_vld), 0, 0);
        check("R5", int'(act_out), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep, back to back (R1 R2 R3 R4 R5 R9)
        for (int c = -NCODES/2; c < NCODES/2; c++) begin
            @(negedge clk);
            act_in_vld = 1'b1;
            act_in     = W'(c);
            @(posedge clk);
            #1;
            check("R5", int'(act_out_vld), 1, c);
            got[c + NCODES/2] = int'(act_out);
            check(req_of(c), int'(act_out), expect_val(c), c);
            if (int'(act_out) > 1024 || int'(act_out) < -1024)
                check("R9", int'(act_out), 1024, c);
        end

        // R6: idle cycles with a changing input; output holds, valid drops (R5)
        prev = int'(act_out);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            act_in_vld = 1'b0;
            act_in     = W'(k * 700 - 2000);
            @(posedge clk);
            #1;
            check("R6", int'(act_out), prev, k);
            check("R5", int'(act_out_vld), 0, k);
        end

        // R7: oddness over the captured curve
        for (int c = 1; c < NCODES/2; c++) begin
            if (got[NCODES/2 - c] != -got[NCODES/2 + c])
                check("R7", got[NCODES/2 - c], -got[NCODES/2 + c], -c);
            else
                n_checks++;
        end

        // R8: monotonic non-decreasing
        for (int i = 1; i < NCODES; i++) begin
            if (got[i] < got[i-1])
                check("R8", got[i], got[i-1], i - NCODES/2);
            else
                n_checks++;
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule